// File: doc/BRIEF.md
# System Power State Controller

This block follows the power condition of the host platform and decides how hard the controller's own clock has to work. Three status lines come in asynchronously: a power-good level, an active-low lid-closed level and an active-low host-suspended level. Each line is brought into the clock domain through a two-flop synchronizer. It is then filtered so that a level counts only after it has been held for several consecutive samples. The filtered lines pick one of four platform states. A one-cycle change pulse accompanies every state transition, so the reporting logic can queue an alert carrying the new state code.

Beside the platform state, the block arbitrates a clock-mode request for the controller. Stop is the default. Wait is requested while any timer-based function, such as LED blinking or an active PWM channel, needs a running timer. Run is requested while work is pending, while an interrupt-causing condition persists, or while a status change is still being filtered, decoded or announced.

Top module: `pwrsys_ctrl`

## Requirements
- R1: Filtered power-good low selects state code 0 (critical suspend), whatever the lid and host-suspended lines show.
- R2: Power-good high with the lid line low selects state code 1 (lid closed), whatever the host-suspended line shows.
- R3: Power-good high, lid high and host-suspended low selects state code 2 (host suspended).
- R4: Power-good, lid and host-suspended all high select state code 3 (active, self-managed).
- R5: The one-hot state output has exactly one bit set, at bit position equal to the state code.
- R6: A status input change takes effect only after it has been held for 3 consecutive synchronized samples. The new state appears 6 clock edges after the input changes, and a pulse of 2 cycles or less never changes the state.
- R7: The change pulse is high for exactly the one cycle in which a new state code first appears, and it is never high when the state is unchanged.
- R8: The clock-mode output is stop (code 0) when no timer, work, interrupt or status-change request is active.
- R9: The clock-mode output is wait (code 1) when any timer request bit is set and no run reason is present.
- R10: The clock-mode output is run (code 2) while work is pending, while the interrupt-hold input is high, or from the cycle a synchronized status level differs from its filtered value until the cycle after the change pulse.
- R11: When several requests are active together, run wins over wait and wait wins over stop.
- R12: After reset the state code is 0, the one-hot output is 0001, the change pulse is low and the clock mode is stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pgood_i | input | 1 | Power-good status, asynchronous, active high |
| lid_n_i | input | 1 | Lid-closed status, asynchronous, active low |
| hsus_n_i | input | 1 | Host-suspended status, asynchronous, active low |
| timer_req_i | input | N_TIMER (2) | Timer demands; bit 0 LED blink, bit 1 PWM active |
| work_pend_i | input | 1 | Event processing pending |
| irq_hold_i | input | 1 | An interrupt-causing input condition persists |
| state_code_o | output | 2 | Current platform state code |
| state_onehot_o | output | 4 | One-hot copy of the state code |
| state_chg_o | output | 1 | Single-cycle state-change pulse |
| clk_mode_o | output | 2 | Clock-mode request: 0 stop, 1 wait, 2 run |

## Verification
The two functions that meet in one cycle are the platform state transition and the clock-mode arbitration. A status change must push the mode to run, even while a timer request is holding it at wait. The collision is provoked by holding a timer request steady while a status line moves. The mode is sampled before filtering starts and during filtering, where it must be wait and then run. It is also sampled in the change-pulse cycle, where it must be run alongside the new state code, and one cycle later, when it must drop back to wait. Short glitches on a status line must also raise run while they are in the synchronizer and leave the state and the pulse untouched.

// File: rtl/pwrsys_pkg.sv
package pwrsys_pkg;

    localparam int STATE_W    = 2;
    localparam int NUM_STATES = 4;
    localparam int MODE_W     = 2;

    typedef enum logic [STATE_W-1:0] {
        SYS_CRIT      = 2'd0,
        SYS_LIDCLOSED = 2'd1,
        SYS_HOSTSUSP  = 2'd2,
        SYS_ACTIVE    = 2'd3
    } sys_state_e;

    typedef enum logic [MODE_W-1:0] {
        CLK_STOP = 2'd0,
        CLK_WAIT = 2'd1,
        CLK_RUN  = 2'd2
    } clk_mode_e;

    typedef struct packed {
        logic hsus_n;
        logic lid_n;
        logic pgood;
    } status_t;

    localparam int      STATUS_W   = $bits(status_t);
    localparam status_t STATUS_RST = '{hsus_n: 1'b1, lid_n: 1'b1, pgood: 1'b0};

    // Priority order matters: power loss dominates, then the lid.
    function automatic sys_state_e decode_status(status_t s);
        sys_state_e r;
        if (!s.pgood)       r = SYS_CRIT;
        else if (!s.lid_n)  r = SYS_LIDCLOSED;
        else if (!s.hsus_n) r = SYS_HOSTSUSP;
        else                r = SYS_ACTIVE;
        return r;
    endfunction

    function automatic logic [NUM_STATES-1:0] state_to_onehot(sys_state_e s);
        return NUM_STATES'(1) << s;
    endfunction

endpackage

// File: rtl/pwrsys_sync_filt.sv
module pwrsys_sync_filt #(
    parameter int               WIDTH       = 3,
    parameter int               SYNC_STAGES = 2,
    parameter int               DB_SAMPLES  = 3,
    parameter logic [WIDTH-1:0] RST_VAL     = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] filt_o,
    output logic             busy_o
);

    localparam int CNT_W = $clog2(DB_SAMPLES + 1);
    localparam int LAST  = SYNC_STAGES - 1;

    logic [WIDTH-1:0] sync_q [SYNC_STAGES];
    logic [WIDTH-1:0] sync_last;
    logic [WIDTH-1:0] filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= RST_VAL;
        end else begin
            sync_q[0] <= raw_i;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    assign sync_last = sync_q[LAST];

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [CNT_W-1:0] cnt_q;
        logic             lvl_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
                lvl_q <= RST_VAL[b];
            end else if (sync_last[b] == lvl_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(DB_SAMPLES - 1)) begin
                cnt_q <= '0;
                lvl_q <= sync_last[b];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        assign filt_q[b] = lvl_q;
    end

    assign filt_o = filt_q;
    assign busy_o = |(sync_last ^ filt_q);

    // A filtered bit may only flip to a level the synchronizer held steady.
    assert_filt_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (filt_q != $past(filt_q)) |->
            ((($past(sync_last) ^ $past(sync_last, 2)) & (filt_q ^ $past(filt_q))) == '0)
            && ((($past(sync_last) ^ filt_q) & (filt_q ^ $past(filt_q))) == '0));

endmodule

// File: rtl/pwrsys_state_fsm.sv
module pwrsys_state_fsm
    import pwrsys_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  status_t    filt_i,
    output sys_state_e state_o,
    output logic       chg_o,
    output logic       pend_o
);

    sys_state_e state_q;
    sys_state_e state_d;
    logic       chg_q;

    always_comb state_d = decode_status(filt_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SYS_CRIT;
            chg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            chg_q   <= (state_d != state_q);
        end
    end

    assign state_o = state_q;
    assign chg_o   = chg_q;
    assign pend_o  = (state_d != state_q);

    assert_crit_forced_R1: assert property (@(posedge clk) disable iff (rst)
        !filt_i.pgood |=> state_q == SYS_CRIT);

    assert_lid_dominant_R2: assert property (@(posedge clk) disable iff (rst)
        (filt_i.pgood && !filt_i.lid_n) |=> state_q == SYS_LIDCLOSED);

    assert_pulse_on_change_R7: assert property (@(posedge clk) disable iff (rst)
        chg_q |-> state_q != $past(state_q));

    assert_change_has_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != $past(state_q)) |-> chg_q);

endmodule

// File: rtl/pwrsys_clk_arb.sv
module pwrsys_clk_arb
    import pwrsys_pkg::*;
#(
    parameter int N_TIMER = 2,
    parameter int N_RUN   = 5
) (
    input  logic [N_TIMER-1:0] timer_req_i,
    input  logic [N_RUN-1:0]   run_req_i,
    output clk_mode_e          mode_o
);

    always_comb begin
        if (|run_req_i)        mode_o = CLK_RUN;
        else if (|timer_req_i) mode_o = CLK_WAIT;
        else                   mode_o = CLK_STOP;
    end

endmodule

// File: rtl/pwrsys_ctrl.sv
module pwrsys_ctrl
    import pwrsys_pkg::*;
#(
    parameter int N_TIMER     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DB_SAMPLES  = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pgood_i,
    input  logic                  lid_n_i,
    input  logic                  hsus_n_i,
    input  logic [N_TIMER-1:0]    timer_req_i,
    input  logic                  work_pend_i,
    input  logic                  irq_hold_i,
    output logic [STATE_W-1:0]    state_code_o,
    output logic [NUM_STATES-1:0] state_onehot_o,
    output logic                  state_chg_o,
    output logic [MODE_W-1:0]     clk_mode_o
);

    localparam int N_RUN = 5;

    status_t          raw_st;
    logic [STATUS_W-1:0] filt_bits;
    status_t          filt_st;
    logic             filt_busy;
    sys_state_e       state;
    logic             chg;
    logic             upd_pend;
    logic [N_RUN-1:0] run_req;
    clk_mode_e        mode;

    assign raw_st = '{hsus_n: hsus_n_i, lid_n: lid_n_i, pgood: pgood_i};

    pwrsys_sync_filt #(
        .WIDTH       (STATUS_W),
        .SYNC_STAGES (SYNC_STAGES),
        .DB_SAMPLES  (DB_SAMPLES),
        .RST_VAL     (STATUS_RST)
    ) u_filt (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw_st),
        .filt_o (filt_bits),
        .busy_o (filt_busy)
    );

    assign filt_st = status_t'(filt_bits);

    pwrsys_state_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .filt_i  (filt_st),
        .state_o (state),
        .chg_o   (chg),
        .pend_o  (upd_pend)
    );

    assign run_req = {work_pend_i, irq_hold_i, filt_busy, upd_pend, chg};

    pwrsys_clk_arb #(
        .N_TIMER (N_TIMER),
        .N_RUN   (N_RUN)
    ) u_arb (
        .timer_req_i (timer_req_i),
        .run_req_i   (run_req),
        .mode_o      (mode)
    );

    assign state_code_o   = state;
    assign state_onehot_o = state_to_onehot(state);
    assign state_chg_o    = chg;
    assign clk_mode_o     = mode;

    assert_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(state_onehot_o) == 1);

    assert_run_prio_R11: assert property (@(posedge clk) disable iff (rst)
        (work_pend_i && (|timer_req_i)) |-> clk_mode_o == CLK_RUN);

    assert_pulse_runs_R10: assert property (@(posedge clk) disable iff (rst)
        state_chg_o |-> clk_mode_o == CLK_RUN);

    assert_stop_default_R8: assert property (@(posedge clk) disable iff (rst)
        (clk_mode_o == CLK_STOP) |->
            (!work_pend_i && !irq_hold_i && !(|timer_req_i) && !state_chg_o));

    assert_wait_needs_timer_R9: assert property (@(posedge clk) disable iff (rst)
        (clk_mode_o == CLK_WAIT) |-> (|timer_req_i) && !work_pend_i && !irq_hold_i);

endmodule

// File: tb/pwrsys_ctrl_tb_top.sv
module pwrsys_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pgood_i = 1'b0;
    logic       lid_n_i = 1'b1;
    logic       hsus_n_i = 1'b1;
    logic [1:0] timer_req_i = 2'b00;
    logic       work_pend_i = 1'b0;
    logic       irq_hold_i = 1'b0;
    logic [1:0] state_code_o;
    logic [3:0] state_onehot_o;
    logic       state_chg_o;
    logic [1:0] clk_mode_o;

    int n_cmp = 0;
    int n_bad = 0;

    localparam int M_STOP = 0, M_WAIT = 1, M_RUN = 2;

    always #4 clk = ~clk;

    pwrsys_ctrl dut_i (
        .clk            (clk),
        .rst            (rst),
        .pgood_i        (pgood_i),
        .lid_n_i        (lid_n_i),
        .hsus_n_i       (hsus_n_i),
        .timer_req_i    (timer_req_i),
        .work_pend_i    (work_pend_i),
        .irq_hold_i     (irq_hold_i),
        .state_code_o   (state_code_o),
        .state_onehot_o (state_onehot_o),
        .state_chg_o    (state_chg_o),
        .clk_mode_o     (clk_mode_o)
    );

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 state", state_code_o, 0);
        check("R12 onehot", state_onehot_o, 1);
        check("R12 pulse", state_chg_o, 0);
        check("R12 mode", clk_mode_o, M_STOP);
    endtask

    // Move the status lines and follow the 6-edge latency; idle_mode is the
    // mode expected when no status work is in flight.
    task automatic t_move(input logic p, input logic l, input logic h,
                          input int exp, input int prev, input int idle_mode, input string tag);
        pgood_i = p; lid_n_i = l; hsus_n_i = h;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (k == 1) check({tag, " R8/R9 mode before sync"}, clk_mode_o, idle_mode);
            if (k == 3) check({tag, " R10 mode while filtering"}, clk_mode_o, M_RUN);
            if (k == 5) begin
                check({tag, " R6 state held"}, state_code_o, prev);
                check({tag, " R7 no early pulse"}, state_chg_o, 0);
            end
            if (k == 6) begin
                check({tag, " state"}, state_code_o, exp);
                check({tag, " R5 onehot"}, state_onehot_o, 1 << exp);
                check({tag, " R7 pulse"}, state_chg_o, 1);
                check({tag, " R10 mode at pulse"}, clk_mode_o, M_RUN);
            end
            if (k == 7) begin
                check({tag, " R7 pulse drop"}, state_chg_o, 0);
                check({tag, " R11 mode after"}, clk_mode_o, idle_mode);
            end
        end
    endtask

    task automatic t_glitch(input int which, input int cur);
        if (which == 0) pgood_i = ~pgood_i; else lid_n_i = ~lid_n_i;
        @(negedge clk);
        @(negedge clk);
        check("R10 mode during glitch", clk_mode_o, M_RUN);
        if (which == 0) pgood_i = ~pgood_i; else lid_n_i = ~lid_n_i;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (state_chg_o) check("R6 glitch pulse", 1, 0);
        end
        check("R6 glitch ignored state", state_code_o, cur);
        check("R8 mode after glitch", clk_mode_o, M_STOP);
    endtask

    task automatic t_modes(input int cur);
        timer_req_i = 2'b01; #1;
        check("R9 led timer wait", clk_mode_o, M_WAIT);
        @(negedge clk);
        timer_req_i = 2'b10; #1;
        check("R9 pwm timer wait", clk_mode_o, M_WAIT);
        @(negedge clk);
        timer_req_i = 2'b00; work_pend_i = 1'b1; #1;
        check("R10 work run", clk_mode_o, M_RUN);
        @(negedge clk);
        work_pend_i = 1'b0; irq_hold_i = 1'b1; #1;
        check("R10 irq hold run", clk_mode_o, M_RUN);
        @(negedge clk);
        irq_hold_i = 1'b0; timer_req_i = 2'b11; work_pend_i = 1'b1; #1;
        check("R11 run over wait", clk_mode_o, M_RUN);
        @(negedge clk);
        timer_req_i = 2'b00; work_pend_i = 1'b0; #1;
        check("R8 back to stop", clk_mode_o, M_STOP);
        @(negedge clk);
        check("R7 no pulse on mode traffic", state_chg_o, 0);
        check("R7 state unchanged", state_code_o, cur);
    endtask

    initial begin
        t_reset();
        t_move(1, 1, 1, 3, 0, M_STOP, "R4 to active");
        t_move(1, 1, 0, 2, 3, M_STOP, "R3 to host suspend");
        t_move(1, 0, 0, 1, 2, M_STOP, "R2 lid over suspend");
        t_move(0, 0, 0, 0, 1, M_STOP, "R1 from lid");
        t_move(1, 1, 1, 3, 0, M_STOP, "R4 back active");
        t_glitch(0, 3);
        t_glitch(1, 3);
        t_modes(3);
        timer_req_i = 2'b01;
        @(negedge clk);
        t_move(1, 1, 0, 2, 3, M_WAIT, "R11 collide suspend");
        t_move(0, 1, 0, 0, 2, M_WAIT, "R1 collide power loss");
        timer_req_i = 2'b00;
        @(negedge clk);
        check("R8 idle end", clk_mode_o, M_STOP);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule